// File: doc/BRIEF.md
# Line-Cycle Energy Accumulation Controller

This block lines up energy readout with the half cycles of the mains. Three phase accumulators add signed energy increments on every clock. A tally counts zero-crossing strobes from phases A, B and C, and a 3-bit select decides which phases take part. When line-cycle mode is on and the tally reaches the programmed half-cycle count, the running sums are copied into the visible energy outputs. The accumulators restart from zero on that same edge, and a sticky status flag is raised. The flag can be masked onto an interrupt line.

When line-cycle mode is off, the visible outputs follow the running sums on every clock. A read strobe can also restart the accumulators when read-with-reset is enabled. Read-with-reset has no effect while line-cycle mode is on. Zero-crossing detection is not part of this block.

Top module: `lcyc_energy_ctrl`

## Requirements
- R1: After reset, all three energy outputs are zero, and both `irq_status` and `irq` are 0.
- R2: Each strobe bit of `zx_strobe` (bit 0 = phase A, bit 1 = B, bit 2 = C) adds one to the half-cycle tally only while the matching bit of `zx_sel` is 1. Selected crossings that arrive in the same cycle each add one.
- R3: With `lcyc_en`=1 and `half_cycles`≠0, a transfer happens in the cycle in which the tally plus that cycle's selected crossings reaches or passes `half_cycles`. From the next cycle, each energy output holds its accumulator plus the increment of the transfer cycle.
- R4: On a transfer edge the accumulators restart at zero, so the next transferred value is exactly the sum of the increments presented after the transfer cycle.
- R5: In line-cycle mode, the energy outputs do not change in any cycle without a transfer.
- R6: With `lcyc_en`=1 and `half_cycles`=0, no transfer ever occurs and the outputs hold. The accumulators keep summing.
- R7: With `lcyc_en`=0, each energy output shows, one cycle later, its accumulator plus that cycle's increment.
- R8: With `lcyc_en`=0, a cycle with `rd_stb`=1 and `rd_rst_en`=1 shows the sum as in R7 and restarts the accumulator at zero. With `rd_rst_en`=0 the read strobe restarts nothing.
- R9: With `lcyc_en`=1, `rd_stb` together with `rd_rst_en` has no effect on the outputs or on the accumulators.
- R10: `irq_status` is set by a transfer and stays set until a cycle with `irq_clr`=1 and no transfer. A transfer and a clear in the same cycle leave it set.
- R11: `irq` is 1 exactly when `irq_status` is 1 and `irq_mask` is 1.
- R12: After a transfer the tally restarts at zero, and surplus crossings from the transfer cycle are dropped. The tally also restarts at zero whenever `lcyc_en` is 0 or `half_cycles` is 0.
- R13: Increments are sign-extended, and the accumulators wrap modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| zx_strobe | input | 3 | Zero-crossing strobes, bit 0 A, bit 1 B, bit 2 C |
| zx_sel | input | 3 | Phase select for the tally |
| lcyc_en | input | 1 | Line-cycle mode enable |
| half_cycles | input | 16 | Half-cycle count per period, 0 disables transfers |
| rd_stb | input | 1 | Read strobe |
| rd_rst_en | input | 1 | Read-with-reset enable (free mode only) |
| irq_clr | input | 1 | Write-one-to-clear strobe for the status flag |
| irq_mask | input | 1 | Interrupt mask |
| inc_a | input | 24 | Signed energy increment, phase A |
| inc_b | input | 24 | Signed energy increment, phase B |
| inc_c | input | 24 | Signed energy increment, phase C |
| eng_a | output | 32 | Visible energy, phase A |
| eng_b | output | 32 | Visible energy, phase B |
| eng_c | output | 32 | Visible energy, phase C |
| irq_status | output | 1 | Sticky end-of-period flag |
| irq | output | 1 | Masked interrupt |

## Verification
Two pairs of events can land in the same cycle. A transfer can coincide with a status clear, and a transfer can coincide with a fresh increment and surplus crossings. The bench provokes both on purpose. It drives `irq_clr` in exactly the cycle in which the tally reaches its target, and it judges that the flag stays set. In that same cycle it presents several selected crossings and a non-zero increment. It then checks that the transferred value includes that increment and that the next period starts empty, with no leftover tally.

// File: rtl/lcyc_pkg.sv
package lcyc_pkg;

    localparam int NPH   = 3;
    localparam int HIT_W = $clog2(NPH + 1);

    // Per-phase update command, produced by the top-level sequencing.
    typedef struct packed {
        logic line_mode;  // visible registers update only on dump
        logic dump;       // copy sum out and restart accumulator
    } acc_cmd_t;

    typedef enum logic [1:0] {
        DUMP_NONE  = 2'd0,
        DUMP_LINE  = 2'd1,
        DUMP_READ  = 2'd2
    } dump_src_e;

    function automatic logic [HIT_W-1:0] count_hits(input logic [NPH-1:0] v);
        logic [HIT_W-1:0] n;
        n = '0;
        for (int i = 0; i < NPH; i++) begin
            n = n + HIT_W'(v[i]);
        end
        return n;
    endfunction

endpackage

// File: rtl/lcyc_halfcycle_cnt.sv
module lcyc_halfcycle_cnt
    import lcyc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [NPH-1:0]   zx,
    input  logic [NPH-1:0]   sel,
    input  logic [CNT_W-1:0] target,
    output logic             xfer
);

    localparam int SUM_W = CNT_W + 1;

    logic [CNT_W-1:0] tally_q;
    logic [HIT_W-1:0] hits;
    logic [SUM_W-1:0] tally_nx;
    logic             active;

    always_comb begin
        active   = en && (target != '0);
        hits     = count_hits(zx & sel);
        tally_nx = {1'b0, tally_q} + {{(SUM_W-HIT_W){1'b0}}, hits};
        xfer     = active && (tally_nx >= {1'b0, target});
    end

    always_ff @(posedge clk) begin
        if (rst || !active || xfer) begin
            tally_q <= '0;
        end else begin
            tally_q <= tally_nx[CNT_W-1:0];
        end
    end

    AST_TALLY_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !active |=> tally_q == '0);                                  // R12
    AST_TALLY_RESTART: assert property (@(posedge clk) disable iff (rst)
        xfer |=> tally_q == '0);                                     // R12
    AST_TALLY_BELOW_TARGET: assert property (@(posedge clk) disable iff (rst)
        (active && $past(active) && $stable(target)) |-> tally_q < target); // R3

endmodule

// File: rtl/lcyc_phase_acc.sv
module lcyc_phase_acc
    import lcyc_pkg::*;
#(
    parameter int INC_W = 24,
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  acc_cmd_t         cmd,
    input  logic [INC_W-1:0] inc,
    output logic [ACC_W-1:0] vis
);

    localparam int EXT_W = ACC_W - INC_W;

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] vis_q;
    logic [ACC_W-1:0] sum;

    always_comb begin
        sum = acc_q + {{EXT_W{inc[INC_W-1]}}, inc};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            vis_q <= '0;
        end else begin
            acc_q <= cmd.dump ? '0 : sum;
            if (!cmd.line_mode || cmd.dump) begin
                vis_q <= sum;
            end
        end
    end

    assign vis = vis_q;

    AST_ACC_RESTART: assert property (@(posedge clk) disable iff (rst)
        cmd.dump |=> acc_q == '0);                                   // R4
    AST_VIS_HOLD: assert property (@(posedge clk) disable iff (rst)
        (cmd.line_mode && !cmd.dump) |=> $stable(vis_q));            // R5

endmodule

// File: rtl/lcyc_irq_flag.sv
module lcyc_irq_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    input  logic mask,
    output logic status,
    output logic irq
);

    logic status_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= 1'b0;
        end else begin
            status_q <= set | (status_q & ~clr);
        end
    end

    assign status = status_q;
    assign irq    = status_q & mask;

    AST_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
        set |=> status_q);                                           // R10
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (status_q && !clr) |=> status_q);                            // R10

endmodule

// File: rtl/lcyc_energy_ctrl.sv
module lcyc_energy_ctrl
    import lcyc_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int INC_W = 24,
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [2:0]       zx_strobe,
    input  logic [2:0]       zx_sel,
    input  logic             lcyc_en,
    input  logic [CNT_W-1:0] half_cycles,
    input  logic             rd_stb,
    input  logic             rd_rst_en,
    input  logic             irq_clr,
    input  logic             irq_mask,
    input  logic [INC_W-1:0] inc_a,
    input  logic [INC_W-1:0] inc_b,
    input  logic [INC_W-1:0] inc_c,
    output logic [ACC_W-1:0] eng_a,
    output logic [ACC_W-1:0] eng_b,
    output logic [ACC_W-1:0] eng_c,
    output logic             irq_status,
    output logic             irq
);

    logic                   xfer;
    dump_src_e              dump_src;
    acc_cmd_t               cmd;
    logic [INC_W-1:0]       inc_v [NPH];
    logic [ACC_W-1:0]       vis_v [NPH];

    lcyc_halfcycle_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .en     (lcyc_en),
        .zx     (zx_strobe),
        .sel    (zx_sel),
        .target (half_cycles),
        .xfer   (xfer)
    );

    // Line mode owns the dump; read-with-reset only acts in free mode.
    always_comb begin
        if (lcyc_en) begin
            dump_src = xfer ? DUMP_LINE : DUMP_NONE;
        end else begin
            dump_src = (rd_stb && rd_rst_en) ? DUMP_READ : DUMP_NONE;
        end
        cmd.line_mode = lcyc_en;
        cmd.dump      = (dump_src != DUMP_NONE);
    end

    assign inc_v[0] = inc_a;
    assign inc_v[1] = inc_b;
    assign inc_v[2] = inc_c;

    for (genvar p = 0; p < NPH; p++) begin : g_phase
        lcyc_phase_acc #(.INC_W(INC_W), .ACC_W(ACC_W)) u_acc (
            .clk (clk),
            .rst (rst),
            .cmd (cmd),
            .inc (inc_v[p]),
            .vis (vis_v[p])
        );
    end

    assign eng_a = vis_v[0];
    assign eng_b = vis_v[1];
    assign eng_c = vis_v[2];

    lcyc_irq_flag u_flag (
        .clk    (clk),
        .rst    (rst),
        .set    (xfer),
        .clr    (irq_clr),
        .mask   (irq_mask),
        .status (irq_status),
        .irq    (irq)
    );

    AST_NO_READ_DUMP_IN_LINE: assert property (@(posedge clk) disable iff (rst)
        lcyc_en |-> dump_src != DUMP_READ);                          // R9
    AST_ZERO_TARGET_NO_XFER: assert property (@(posedge clk) disable iff (rst)
        (half_cycles == '0) |=> !$rose(irq_status));                 // R6

endmodule

// File: tb/sim_lcyc_energy_ctrl.sv
module sim_lcyc_energy_ctrl;

    logic        clk = 1'b0;
    logic        rst;
    logic [2:0]  zx_strobe, zx_sel;
    logic        lcyc_en, rd_stb, rd_rst_en, irq_clr, irq_mask;
    logic [15:0] half_cycles;
    logic [23:0] inc_a, inc_b, inc_c;
    logic [31:0] eng_a, eng_b, eng_c;
    logic        irq_status, irq;

    int n_chk = 0;
    int n_bad = 0;

    // reference state
    logic [31:0] acc_m [3];
    logic [31:0] vis_m [3];
    int          tally_m;
    logic        stat_m;

    always #10 clk = ~clk;

    lcyc_energy_ctrl u0 (
        .clk(clk), .rst(rst), .zx_strobe(zx_strobe), .zx_sel(zx_sel),
        .lcyc_en(lcyc_en), .half_cycles(half_cycles), .rd_stb(rd_stb),
        .rd_rst_en(rd_rst_en), .irq_clr(irq_clr), .irq_mask(irq_mask),
        .inc_a(inc_a), .inc_b(inc_b), .inc_c(inc_c),
        .eng_a(eng_a), .eng_b(eng_b), .eng_c(eng_c),
        .irq_status(irq_status), .irq(irq)
    );

    task automatic report();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run hung, actual=running expected=finished");
        report();
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_model(input string req);
        check({req, " eng_a"}, eng_a, vis_m[0]);
        check({req, " eng_b"}, eng_b, vis_m[1]);
        check({req, " eng_c"}, eng_c, vis_m[2]);
        check({req, " status"}, 32'(irq_status), 32'(stat_m));
        check({req, " R11 irq"}, 32'(irq), 32'(stat_m & irq_mask));
    endtask

    // One clock: present inputs, advance reference, wait past the edge.
    task automatic cyc(input logic [2:0] zx, input int ia, input int ib, input int ic,
                       input logic rd, input logic clr);
        int   hits;
        bit   act, xf, dmp;
        int   incs [3];
        logic [31:0] s;
        zx_strobe = zx; rd_stb = rd; irq_clr = clr;
        inc_a = ia[23:0]; inc_b = ib[23:0]; inc_c = ic[23:0];
        incs[0] = ia; incs[1] = ib; incs[2] = ic;
        hits = 0;
        for (int k = 0; k < 3; k++) if (zx[k] && zx_sel[k]) hits++;
        act = lcyc_en && (half_cycles != 0);
        xf  = act && ((tally_m + hits) >= int'(half_cycles));
        dmp = lcyc_en ? xf : (rd && rd_rst_en);
        for (int k = 0; k < 3; k++) begin
            s = acc_m[k] + 32'(incs[k]);
            if (!lcyc_en || dmp) vis_m[k] = s;
            acc_m[k] = dmp ? 32'd0 : s;
        end
        tally_m = (!act || xf) ? 0 : tally_m + hits;
        stat_m  = xf | (stat_m & ~clr);
        @(posedge clk);
        #1;
        zx_strobe = '0; rd_stb = 0; irq_clr = 0;
    endtask

    task automatic t_reset();
        check("R1 eng_a", eng_a, 32'd0);
        check("R1 eng_b", eng_b, 32'd0);
        check("R1 eng_c", eng_c, 32'd0);
        check("R1 status", 32'(irq_status), 32'd0);
        check("R1 irq", 32'(irq), 32'd0);
    endtask

    task automatic t_single_phase();
        lcyc_en = 1; zx_sel = 3'b001; half_cycles = 16'd3; irq_mask = 0;
        cyc(3'b000, 10, -5, 7, 0, 0);
        cyc(3'b001, 10, -5, 7, 0, 0);
        cyc(3'b110, 10, -5, 7, 0, 0);   // unselected phases, R2
        cyc(3'b001, 10, -5, 7, 0, 0);
        cyc(3'b000, 10, -5, 7, 0, 0);
        check("R5 hold before target", eng_a, 32'd0);
        check("R2 no early transfer", 32'(irq_status), 32'd0);
        cyc(3'b001, 10, -5, 7, 0, 0);
        check("R3 eng_a", eng_a, 32'd60);
        check("R3 eng_b", eng_b, 32'hFFFF_FFE2);
        check("R3 eng_c", eng_c, 32'd42);
        check("R10 set", 32'(irq_status), 32'd1);
        check("R11 masked", 32'(irq), 32'd0);
        cyc(3'b001, 1, 1, 1, 0, 0);
        cyc(3'b001, 2, 2, 2, 0, 0);
        cyc(3'b001, 3, 3, 3, 0, 0);
        check("R4 fresh period", eng_a, 32'd6);
        check_model("R4");
    endtask

    task automatic t_simultaneous();
        irq_mask = 1;
        cyc(3'b000, 0, 0, 0, 0, 1);
        check("R10 cleared", 32'(irq_status), 32'd0);
        zx_sel = 3'b111; half_cycles = 16'd4;
        cyc(3'b111, 5, 5, 5, 0, 0);
        check("R2 three crossings not yet 4", 32'(irq_status), 32'd0);
        cyc(3'b011, 5, 5, 5, 0, 1);     // transfer and clear together
        check("R2 simultaneous counted", eng_a, 32'd10);
        check("R10 set beats clear", 32'(irq_status), 32'd1);
        check("R11 irq unmasked", 32'(irq), 32'd1);
        for (int i = 0; i < 3; i++) cyc(3'b001, 1, 1, 1, 0, 0);
        check("R12 surplus dropped", eng_a, 32'd10);
        cyc(3'b001, 1, 1, 1, 0, 1);
        check("R12 next period", eng_a, 32'd4);
        check("R10 set beats clear again", 32'(irq_status), 32'd1);
        cyc(3'b000, 0, 0, 0, 0, 1);
        check("R11 irq drops", 32'(irq), 32'd0);
        check_model("R12");
    endtask

    task automatic t_zero_target();
        half_cycles = 16'd0;
        for (int i = 0; i < 10; i++) cyc(3'b111, 2, 2, 2, 0, 0);
        check("R6 no transfer", eng_a, 32'd4);
        check("R6 no flag", 32'(irq_status), 32'd0);
        half_cycles = 16'd2;
        cyc(3'b001, 2, 2, 2, 0, 0);
        cyc(3'b001, 2, 2, 2, 0, 0);
        check("R6 accumulators kept summing", eng_a, 32'd24);
        check_model("R6");
    endtask

    task automatic t_mode_toggle();
        zx_sel = 3'b001; half_cycles = 16'd3;
        cyc(3'b000, 0, 0, 0, 0, 1);
        cyc(3'b001, 1, 1, 1, 0, 0);
        cyc(3'b001, 1, 1, 1, 0, 0);
        lcyc_en = 0;
        cyc(3'b000, 1, 1, 1, 0, 0);
        check("R7 free mode shows sum", eng_a, 32'd3);
        lcyc_en = 1;
        cyc(3'b001, 1, 1, 1, 0, 0);
        check("R12 tally restarted", 32'(irq_status), 32'd0);
        cyc(3'b001, 1, 1, 1, 0, 0);
        cyc(3'b001, 1, 1, 1, 0, 0);
        check("R12 full count needed", eng_a, 32'd6);
        check_model("R12 toggle");
    endtask

    task automatic t_free_read();
        lcyc_en = 0; rd_rst_en = 1;
        cyc(3'b000, 3, 3, 3, 1, 0);
        check("R8 read shows sum", eng_a, 32'd3);
        cyc(3'b000, 4, 4, 4, 0, 0);
        check("R8 restarted", eng_a, 32'd4);
        rd_rst_en = 0;
        cyc(3'b000, 4, 4, 4, 1, 0);
        cyc(3'b000, 1, 1, 1, 0, 0);
        check("R8 no restart without enable", eng_a, 32'd9);
        check("R7 eng_c tracks", eng_c, 32'd9);
        check_model("R7");
    endtask

    task automatic t_read_ignored();
        lcyc_en = 1; rd_rst_en = 1; zx_sel = 3'b001; half_cycles = 16'd2;
        cyc(3'b000, 1, 1, 1, 1, 0);
        cyc(3'b000, 1, 1, 1, 1, 0);
        check("R9 outputs untouched", eng_a, 32'd9);
        cyc(3'b001, 1, 1, 1, 1, 0);
        cyc(3'b001, 1, 1, 1, 0, 0);
        check("R9 nothing lost", eng_a, 32'd13);
        check_model("R9");
    endtask

    task automatic t_wrap();
        lcyc_en = 0; rd_rst_en = 1;
        cyc(3'b000, 0, 0, 0, 1, 0);
        for (int i = 0; i < 512; i++) cyc(3'b000, 24'h7FFFFF, -8388608, 0, 0, 0);
        check("R13 eng_a", eng_a, 32'hFFFF_FE00);
        check("R13 eng_b wraps to zero", eng_b, 32'd0);
        cyc(3'b000, 24'h7FFFFF, -8388608, 0, 0, 0);
        check("R13 eng_a wrapped", eng_a, 32'h007F_FDFF);
        check("R13 eng_b sign", eng_b, 32'hFF80_0000);
        check_model("R13");
    endtask

    initial begin
        rst = 1; zx_strobe = '0; zx_sel = '0; lcyc_en = 0; half_cycles = '0;
        rd_stb = 0; rd_rst_en = 0; irq_clr = 0; irq_mask = 0;
        inc_a = '0; inc_b = '0; inc_c = '0;
        for (int k = 0; k < 3; k++) begin acc_m[k] = '0; vis_m[k] = '0; end
        tally_m = 0; stat_m = 0;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        t_reset();
        t_single_phase();
        t_simultaneous();
        t_zero_target();
        t_mode_toggle();
        t_free_read();
        t_read_ignored();
        t_wrap();
        report();
    end

endmodule